// File: doc/BRIEF.md
# Single-Wire Master Control and Bit-Clock Block

This block holds the configuration state of a single-wire serial master and produces its bit-rate tick. A small register bus with address, write data, write strobe and combinational read data reaches two registers. The control register carries the two DMA enables and the receive buffering mode bit. The bitrate register carries a prescaler that sets how many kernel clocks make one bit period.

The block decodes a buffer mode for each direction from these bits. While the link is active, the receive mode bit and the prescaler cannot be written. The transmit DMA enable is cleared by hardware when a frame's first word announces a zero-length payload, or when a transmit underrun is reported. Each such clear raises a sticky flag, which stays set until it is acknowledged.

While the link is active, the bit clock counts kernel clocks. It emits a one-cycle tick at the end of each full bit period. While the link is idle, the counter is held at zero.

Top module: `swm_ctrl_regs`

## Requirements
- R1: After reset, the control register reads 0x00000000 and the bitrate register reads 0x00000001. Both buffer modes are 2'b00, the sticky flag is low and no tick is produced.
- R2: The control register is at offset 0x00. Bit 0 is the receive DMA enable, bit 1 is the transmit DMA enable and bit 2 is the receive buffering mode. Bits 31:3 read as zero, and writes to them have no effect.
- R3: The bitrate register is at offset 0x04, with the prescaler in bits 5:0. Bits 31:6 read as zero, and any other offset reads as zero.
- R4: Buffer mode encoding is 2'b00 for no buffer, 2'b01 for a single buffer and 2'b10 for multiple buffers. The receive mode is 2'b00 when its DMA enable is 0. Otherwise it is 2'b01 or 2'b10 as the mode bit is 0 or 1. The transmit mode is 2'b00 when its DMA enable is 0 and 2'b01 when it is 1.
- R5: A control write while the link is active updates both DMA enables but leaves the receive mode bit unchanged.
- R6: A bitrate write while the link is active leaves the prescaler unchanged.
- R7: A first-word strobe whose low payload byte is 0x00 clears the transmit DMA enable. A nonzero byte leaves it unchanged.
- R8: A transmit underrun pulse clears the transmit DMA enable.
- R9: When a hardware clear and a software write that sets the transmit DMA enable occur in the same cycle, the enable ends up cleared.
- R10: Each hardware clear sets the sticky flag. The flag stays set until an acknowledge pulse clears it. When a set and an acknowledge occur in the same cycle, the flag stays set.
- R11: While the link is active, a one-cycle tick occurs every (prescaler+1)*4 kernel clocks. The first tick falls in the last cycle of the first full period after the link becomes active.
- R12: While the link is inactive, no tick occurs, and the period count restarts from zero at the next activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr |
| link_active | input | 1 | Link busy; locks the mode bit and prescaler, enables the bit clock |
| tx_first_wr | input | 1 | First word of a transmit frame is being written |
| tx_first_lsb | input | PLEN_W | Payload size byte of that first word |
| tx_underrun | input | 1 | Transmit underrun event pulse |
| hw_clr_ack | input | 1 | Acknowledge for the sticky clear flag |
| rx_dma_en | output | 1 | Receive DMA enable |
| tx_dma_en | output | 1 | Transmit DMA enable |
| rx_buf_mode | output | 2 | Decoded receive buffer mode |
| tx_buf_mode | output | 2 | Decoded transmit buffer mode |
| hw_clr_sticky | output | 1 | A hardware clear of the transmit DMA enable has occurred |
| bit_tick | output | 1 | One-cycle bit-period tick |

## Verification
A corrupted control or prescaler register shows on the read port in the same cycle it is addressed. A corrupted DMA enable shows on the buffer mode outputs at once. A lock that leaks shows on the first read after a write made during link activity. A counter that fails to reload, or that runs while idle, shifts the tick: the measured gap from link activation to the first tick and between ticks differs by at least one cycle within one bit period. A missed hardware clear or a lost sticky flag is visible on the cycle after the event.

// File: rtl/swm_pkg.sv
package swm_pkg;
   localparam int DATA_W = 32;
   localparam int OFF_CTRL = 0;
   localparam int OFF_RATE = 4;
   localparam int BIT_RXDMA = 0;
   localparam int BIT_TXDMA = 1;
   localparam int BIT_RXMODE = 2;
   localparam int BR_RESET = 1;

   typedef enum logic [1:0] {
      BUF_NONE   = 2'b00,
      BUF_SINGLE = 2'b01,
      BUF_MULTI  = 2'b10
   } buf_mode_e;
endpackage

// File: rtl/swm_buf_decode.sv
module swm_buf_decode
   import swm_pkg::*;
(
   input  logic      dma_en,
   input  logic      mode_bit,
   output buf_mode_e buf_mode
);
   always_comb begin
      if (!dma_en)
         buf_mode = BUF_NONE;
      else if (mode_bit)
         buf_mode = BUF_MULTI;
      else
         buf_mode = BUF_SINGLE;
   end
endmodule

// File: rtl/swm_bit_clock.sv
module swm_bit_clock #(
   parameter int BR_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [BR_W-1:0] prescale,
   output logic            tick
);
   localparam int CNT_W = BR_W + 2;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   // (prescale+1)*4 - 1
   assign last = {prescale, 2'b11};
   assign tick = run && (cnt == last);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else if (cnt == last)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/swm_ctrl_bank.sv
module swm_ctrl_bank
   import swm_pkg::*;
#(
   parameter int BR_W   = 6,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              locked,
   input  logic              hw_clr,
   input  logic              hw_clr_ack,
   output logic              rx_dma,
   output logic              tx_dma,
   output logic              rx_mode,
   output logic [BR_W-1:0]   br,
   output logic              sticky
);
   logic ctrl_sel, rate_sel;

   assign ctrl_sel = (bus_addr == ADDR_W'(OFF_CTRL));
   assign rate_sel = (bus_addr == ADDR_W'(OFF_RATE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_dma  <= 1'b0;
         tx_dma  <= 1'b0;
         rx_mode <= 1'b0;
         br      <= BR_W'(BR_RESET);
         sticky  <= 1'b0;
      end else begin
         if (bus_we && ctrl_sel) begin
            rx_dma <= bus_wdata[BIT_RXDMA];
            tx_dma <= bus_wdata[BIT_TXDMA];
            if (!locked)
               rx_mode <= bus_wdata[BIT_RXMODE];
         end
         // hardware clear overrides a same-cycle software write
         if (hw_clr)
            tx_dma <= 1'b0;
         if (bus_we && rate_sel && !locked)
            br <= bus_wdata[BR_W-1:0];
         if (hw_clr)
            sticky <= 1'b1;
         else if (hw_clr_ack)
            sticky <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (ctrl_sel) begin
         bus_rdata[BIT_RXDMA]  = rx_dma;
         bus_rdata[BIT_TXDMA]  = tx_dma;
         bus_rdata[BIT_RXMODE] = rx_mode;
      end else if (rate_sel) begin
         bus_rdata[BR_W-1:0] = br;
      end
   end
endmodule

// File: rtl/swm_ctrl_regs.sv
module swm_ctrl_regs
   import swm_pkg::*;
#(
   parameter int BR_W   = 6,
   parameter int ADDR_W = 3,
   parameter int PLEN_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_we,
   output logic [31:0]       bus_rdata,
   input  logic              link_active,
   input  logic              tx_first_wr,
   input  logic [PLEN_W-1:0] tx_first_lsb,
   input  logic              tx_underrun,
   input  logic              hw_clr_ack,
   output logic              rx_dma_en,
   output logic              tx_dma_en,
   output logic [1:0]        rx_buf_mode,
   output logic [1:0]        tx_buf_mode,
   output logic              hw_clr_sticky,
   output logic              bit_tick
);
   localparam int NDIR = 2;

   if (BR_W < 1 || BR_W > 16) begin : g_bad_br
      $error("BR_W out of range");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too small for offset 4");
   end
   if (PLEN_W < 1) begin : g_bad_plen
      $error("PLEN_W must be positive");
   end

   logic            hw_clr;
   logic            rx_mode_bit;
   logic [BR_W-1:0] br_val;
   logic [NDIR-1:0] dma_vec;
   logic [NDIR-1:0] mode_vec;
   buf_mode_e       mode_arr [NDIR];

   assign hw_clr = tx_underrun || (tx_first_wr && (tx_first_lsb == '0));

   swm_ctrl_bank #(.BR_W(BR_W), .ADDR_W(ADDR_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_we     (bus_we),
      .bus_rdata  (bus_rdata),
      .locked     (link_active),
      .hw_clr     (hw_clr),
      .hw_clr_ack (hw_clr_ack),
      .rx_dma     (rx_dma_en),
      .tx_dma     (tx_dma_en),
      .rx_mode    (rx_mode_bit),
      .br         (br_val),
      .sticky     (hw_clr_sticky)
   );

   // index 0: receive, index 1: transmit (no mode bit, single buffer only)
   assign dma_vec  = {tx_dma_en, rx_dma_en};
   assign mode_vec = {1'b0, rx_mode_bit};

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      swm_buf_decode u_dec (
         .dma_en   (dma_vec[d]),
         .mode_bit (mode_vec[d]),
         .buf_mode (mode_arr[d])
      );
   end

   assign rx_buf_mode = mode_arr[0];
   assign tx_buf_mode = mode_arr[1];

   swm_bit_clock #(.BR_W(BR_W)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (link_active),
      .prescale (br_val),
      .tick     (bit_tick)
   );
endmodule

// File: rtl/swm_ctrl_regs_chk.sv
module swm_ctrl_regs_chk #(
   parameter int BR_W   = 6,
   parameter int PLEN_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              link_active,
   input logic              tx_first_wr,
   input logic [PLEN_W-1:0] tx_first_lsb,
   input logic              tx_underrun,
   input logic              hw_clr_ack,
   input logic              rx_mode_bit,
   input logic [BR_W-1:0]   br_val,
   input logic              rx_dma_en,
   input logic              tx_dma_en,
   input logic [1:0]        rx_buf_mode,
   input logic              hw_clr_sticky,
   input logic              bit_tick
);
   logic clr_evt;
   assign clr_evt = tx_underrun || (tx_first_wr && (tx_first_lsb == '0));

   p_mode_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      link_active |=> $stable(rx_mode_bit));

   p_rate_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      link_active |=> $stable(br_val));

   p_zero_len_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_first_wr && (tx_first_lsb == '0)) |=> !tx_dma_en);

   p_underrun_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun |=> !tx_dma_en);

   p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_evt |=> hw_clr_sticky);

   p_no_idle_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !link_active |-> !bit_tick);

   p_tick_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |=> !bit_tick);

   p_rx_off_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_dma_en |-> (rx_buf_mode == 2'b00));
endmodule

bind swm_ctrl_regs swm_ctrl_regs_chk #(.BR_W(BR_W), .PLEN_W(PLEN_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .link_active   (link_active),
   .tx_first_wr   (tx_first_wr),
   .tx_first_lsb  (tx_first_lsb),
   .tx_underrun   (tx_underrun),
   .hw_clr_ack    (hw_clr_ack),
   .rx_mode_bit   (rx_mode_bit),
   .br_val        (br_val),
   .rx_dma_en     (rx_dma_en),
   .tx_dma_en     (tx_dma_en),
   .rx_buf_mode   (rx_buf_mode),
   .hw_clr_sticky (hw_clr_sticky),
   .bit_tick      (bit_tick)
);

// File: tb/tb_swm_ctrl_regs.sv
`timescale 1ns/1ps
module tb_swm_ctrl_regs;
   localparam int ADDR_W = 3;
   localparam int PLEN_W = 8;
   localparam int NV = 7;

   // control write vectors: data written, expected readback, rx mode, tx mode
   localparam logic [31:0] V_WD [NV] = '{32'h0, 32'h1, 32'h2, 32'h5, 32'h7, 32'hFFFF_FFF8, 32'h4};
   localparam logic [31:0] V_RD [NV] = '{32'h0, 32'h1, 32'h2, 32'h5, 32'h7, 32'h0, 32'h4};
   localparam logic [1:0]  V_RX [NV] = '{2'b00, 2'b01, 2'b00, 2'b10, 2'b10, 2'b00, 2'b00};
   localparam logic [1:0]  V_TX [NV] = '{2'b00, 2'b00, 2'b01, 2'b00, 2'b01, 2'b00, 2'b00};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic link_active = 1'b0;
   logic tx_first_wr = 1'b0;
   logic [PLEN_W-1:0] tx_first_lsb = '0;
   logic tx_underrun = 1'b0;
   logic hw_clr_ack = 1'b0;
   logic rx_dma_en, tx_dma_en, hw_clr_sticky, bit_tick;
   logic [1:0] rx_buf_mode, tx_buf_mode;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   swm_ctrl_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .link_active(link_active),
      .tx_first_wr(tx_first_wr), .tx_first_lsb(tx_first_lsb),
      .tx_underrun(tx_underrun), .hw_clr_ack(hw_clr_ack),
      .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
      .rx_buf_mode(rx_buf_mode), .tx_buf_mode(tx_buf_mode),
      .hw_clr_sticky(hw_clr_sticky), .bit_tick(bit_tick)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // all drives happen at the falling edge; outputs sampled there too
   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic pulse_first(input logic [PLEN_W-1:0] lsb);
      tx_first_wr = 1'b1; tx_first_lsb = lsb;
      @(negedge clk);
      tx_first_wr = 1'b0;
   endtask

   task automatic pulse_ack();
      hw_clr_ack = 1'b1;
      @(negedge clk);
      hw_clr_ack = 1'b0;
   endtask

   // posedges from current falling edge until tick is seen
   task automatic gap(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!bit_tick && n < 1000);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int g;
      int ticks;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(3'd0, rd); chk("R1 ctrl reset", rd, 32'h0);
      bus_read(3'd4, rd); chk("R1 rate reset", rd, 32'h1);
      chk("R1 modes reset", {28'h0, rx_buf_mode, tx_buf_mode}, 32'h0);
      chk("R1 sticky reset", {31'h0, hw_clr_sticky}, 32'h0);
      chk("R1 no tick", {31'h0, bit_tick}, 32'h0);

      // R2 / R4 vector table
      for (int i = 0; i < NV; i++) begin
         bus_write(3'd0, V_WD[i]);
         bus_read(3'd0, rd);
         chk("R2 ctrl readback", rd, V_RD[i]);
         chk("R4 rx mode", {30'h0, rx_buf_mode}, {30'h0, V_RX[i]});
         chk("R4 tx mode", {30'h0, tx_buf_mode}, {30'h0, V_TX[i]});
      end

      // R3 bitrate field and address decode
      bus_write(3'd4, 32'hFFFF_FF85);
      bus_read(3'd4, rd); chk("R3 rate upper bits zero", rd, 32'h5);
      bus_read(3'd2, rd); chk("R3 unmapped offset", rd, 32'h0);
      bus_write(3'd4, 32'h1);

      // R5 / R6 locks while the link is active
      bus_write(3'd0, 32'h0);
      link_active = 1'b1;
      bus_write(3'd0, 32'h7);
      bus_read(3'd0, rd); chk("R5 mode locked, enables written", rd, 32'h3);
      chk("R5 rx mode single", {30'h0, rx_buf_mode}, 32'h1);
      bus_write(3'd4, 32'h3F);
      bus_read(3'd4, rd); chk("R6 rate locked", rd, 32'h1);
      link_active = 1'b0;
      bus_write(3'd0, 32'h0);

      // R12 idle: no tick
      ticks = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (bit_tick) ticks++;
      end
      chk("R12 no idle tick", ticks, 0);

      // R11 prescaler 1 -> period 8; first gap period-1 from activation
      link_active = 1'b1;
      gap(g); chk("R11 first tick br=1", g, 7);
      gap(g); chk("R11 period br=1", g, 8);
      gap(g); chk("R11 period br=1 again", g, 8);
      // R12 restart from zero after an idle stretch mid-period
      repeat (3) @(negedge clk);
      link_active = 1'b0;
      repeat (5) @(negedge clk);
      link_active = 1'b1;
      gap(g); chk("R12 restart full period", g, 7);
      link_active = 1'b0;
      bus_write(3'd4, 32'h0);
      link_active = 1'b1;
      gap(g); chk("R11 first tick br=0", g, 3);
      gap(g); chk("R11 period br=0", g, 4);
      link_active = 1'b0;
      bus_write(3'd4, 32'h3);
      link_active = 1'b1;
      gap(g); chk("R11 first tick br=3", g, 15);
      gap(g); chk("R11 period br=3", g, 16);
      link_active = 1'b0;
      @(negedge clk);

      // R7 zero-length payload clear
      bus_write(3'd0, 32'h2);
      pulse_first(8'h05);
      chk("R7 nonzero payload keeps tx dma", {31'h0, tx_dma_en}, 32'h1);
      chk("R10 no sticky on nonzero", {31'h0, hw_clr_sticky}, 32'h0);
      pulse_first(8'h00);
      chk("R7 zero payload clears tx dma", {31'h0, tx_dma_en}, 32'h0);
      bus_read(3'd0, rd); chk("R7 ctrl readback", rd, 32'h0);
      chk("R10 sticky set", {31'h0, hw_clr_sticky}, 32'h1);
      repeat (3) @(negedge clk);
      chk("R10 sticky holds", {31'h0, hw_clr_sticky}, 32'h1);
      pulse_ack();
      chk("R10 ack clears sticky", {31'h0, hw_clr_sticky}, 32'h0);

      // R8 underrun clear
      bus_write(3'd0, 32'h3);
      tx_underrun = 1'b1; @(negedge clk); tx_underrun = 1'b0;
      chk("R8 underrun clears tx dma", {31'h0, tx_dma_en}, 32'h0);
      chk("R8 rx dma untouched", {31'h0, rx_dma_en}, 32'h1);
      pulse_ack();

      // R9 hardware clear wins over same-cycle write
      tx_underrun = 1'b1;
      bus_write(3'd0, 32'h2);
      tx_underrun = 1'b0;
      chk("R9 hw clear priority", {31'h0, tx_dma_en}, 32'h0);

      // R10 set wins over same-cycle ack
      pulse_ack();
      tx_underrun = 1'b1; hw_clr_ack = 1'b1;
      @(negedge clk);
      tx_underrun = 1'b0; hw_clr_ack = 1'b0;
      chk("R10 set beats ack", {31'h0, hw_clr_sticky}, 32'h1);
      pulse_ack();
      chk("R10 final ack", {31'h0, hw_clr_sticky}, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule